// File: doc/BRIEF.md
# Serial VID Register Bank

This block holds the addressable byte registers that a voltage-regulator controller exposes to its host over a serial VID link. A bus front end, which is not part of this block, decodes each transaction into a register index, a write byte and a read or write strobe. This bank answers reads with one byte and applies writes to the registers that software may change. It also drives the programmed VID, power state and margin offset to the downstream regulation logic.

Several kinds of register sit behind the one index. Identity bytes are fixed constants. Telemetry bytes are live inputs. The output-current byte is scaled against a maximum-current code that is captured once at power-up. A status byte has a shadow copy that is refreshed whenever the original is read. A VID write is compared with a programmable ceiling, and the front end is told through a one-cycle flag when such a write is refused. A second one-cycle flag reports writes aimed at any index that cannot be written.

The reset input clears the bank asynchronously. Its release is synchronised inside the block.

Top module: `svid_regbank`

## Requirements
- R1: Reads of index 00h, 01h, 02h, 05h, 06h, 24h and 25h return 1Ah, 13h, 01h, 02h, C7h, 0Ah and 02h. Read data is registered: it appears on rd_data in the cycle after the clock edge that samples rd_en, and it holds until the next read.
- R2: Indices 22h (temperature ceiling), 30h (VID ceiling), 31h (VID), 32h (power state) and 33h (offset) are read/write. After reset they hold 64h, B5h, 00h, 00h and 00h. A write to one of them is visible from the next cycle. A read in the same cycle as a write returns the value before the write.
- R3: A write to 31h whose data is greater than the current contents of 30h leaves the VID unchanged and raises nsup_ack for exactly one cycle. A write equal to or below the ceiling is accepted and leaves nsup_ack low.
- R4: A read of 11h copies the stat2_in byte sampled at that edge into a shadow that reads back at 1Ch. Reading 1Ch does not change the shadow.
- R5: The first icc_capture pulse after reset stores icc_meas into the read-only byte at 21h, and later pulses have no effect. 21h reads 00h until the first capture.
- R6: Index 15h returns FFh when iout_amps is greater than or equal to the captured maximum current, or when no capture has happened (the captured value is 00h). Otherwise it returns floor(iout_amps*255/maximum).
- R7: vid_out, pstate_out and offset_out continuously present the stored 31h, 32h and 33h bytes. The offset is kept unaltered as a two's-complement step count (01h = +1 step, FFh = -1 step).
- R8: Reads of any index without a register (for example 03h, 04h, 12h, FFh) return 00h.
- R9: A write to any index other than 22h, 30h, 31h, 32h or 33h changes no state and raises err_ack for exactly one cycle. err_ack and nsup_ack are never high together.
- R10: While rst_n is low every register is at its reset value. After rst_n rises, the first two clock edges still act as reset, so a write held across them is lost.
- R11: Indices 10h, 11h, 16h and 17h return stat1_in, stat2_in, vout_in and temp_in as sampled at the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | AW (8) | Decoded register index |
| wr_data | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| stat1_in | input | 8 | Live status-1 byte |
| stat2_in | input | 8 | Live status-2 byte |
| iout_amps | input | 8 | Measured load current, 1 A per LSB |
| vout_in | input | 8 | Measured output voltage byte |
| temp_in | input | 8 | Measured temperature byte |
| icc_meas | input | 8 | Maximum-current code measured at power-up |
| icc_capture | input | 1 | Strobe that captures icc_meas (first one only) |
| rd_data | output | 8 | Registered read byte |
| nsup_ack | output | 1 | One-cycle pulse: VID write refused |
| err_ack | output | 1 | One-cycle pulse: write to a non-writable index |
| vid_out | output | 8 | Programmed VID |
| pstate_out | output | 8 | Programmed power state |
| offset_out | output | 8 | Programmed margin offset |

## Verification
The hardest case to reach is a refused VID write against a ceiling that is not the default. Reaching it needs a lowered 30h, a 31h write exactly one code above it and another exactly at it, with the VID then read back to show it did not move. The bench builds this in order, and then mixes ceiling writes, VID writes and shadow reads in a long pseudo-random run. During that run a behavioural model is compared on every clock. A second subtle case is the scaled current byte just below, at and above the captured maximum. This is covered by capturing first and then sweeping iout_amps across that edge.

// File: rtl/svid_regbank_pkg.sv
`timescale 1ns/1ps
package svid_regbank_pkg;
  localparam int DW   = 8;
  localparam int RW_N = 5;

  // writable slot numbers
  localparam int SL_TMAX = 0;
  localparam int SL_VMAX = 1;
  localparam int SL_VID  = 2;
  localparam int SL_PST  = 3;
  localparam int SL_OFS  = 4;

  localparam logic [RW_N-1:0][DW-1:0] RW_IDX = {8'h33, 8'h32, 8'h31, 8'h30, 8'h22};
  localparam logic [RW_N-1:0][DW-1:0] RW_DEF = {8'h00, 8'h00, 8'h00, 8'hB5, 8'h64};

  localparam logic [DW-1:0] IX_STAT1  = 8'h10;
  localparam logic [DW-1:0] IX_STAT2  = 8'h11;
  localparam logic [DW-1:0] IX_IOUT   = 8'h15;
  localparam logic [DW-1:0] IX_VOUT   = 8'h16;
  localparam logic [DW-1:0] IX_TEMP   = 8'h17;
  localparam logic [DW-1:0] IX_SHADOW = 8'h1C;
  localparam logic [DW-1:0] IX_ICCMAX = 8'h21;

  typedef struct packed {
    logic          hit;
    logic [DW-1:0] val;
  } const_hit_t;

  function automatic const_hit_t const_lookup(input logic [DW-1:0] idx);
    const_hit_t r;
    r.hit = 1'b1;
    case (idx)
      8'h00:   r.val = 8'h1A;
      8'h01:   r.val = 8'h13;
      8'h02:   r.val = 8'h01;
      8'h05:   r.val = 8'h02;
      8'h06:   r.val = 8'hC7;
      8'h24:   r.val = 8'h0A;
      8'h25:   r.val = 8'h02;
      default: begin r.hit = 1'b0; r.val = '0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/svid_rst_sync.sv
`timescale 1ns/1ps
module svid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/svid_cfg_regs.sv
`timescale 1ns/1ps
module svid_cfg_regs
  import svid_regbank_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            idx,
  input  logic [DW-1:0]            wdata,
  input  logic                     wr_en,
  output logic [RW_N-1:0][DW-1:0]  rw_q,
  output logic                     nsup_q,
  output logic                     err_q
);
  logic [RW_N-1:0] sel;
  logic [RW_N-1:0] ld;
  logic            over_ceiling;
  logic            nsup_d, err_d;

  assign over_ceiling = wdata > rw_q[SL_VMAX];

  for (genvar i = 0; i < RW_N; i++) begin : g_slot
    logic [DW-1:0] q, d;
    assign sel[i] = wr_en && (idx == AW'(RW_IDX[i]));
    if (i == SL_VID) begin : g_ceil
      assign ld[i] = sel[i] && !over_ceiling;
    end else begin : g_plain
      assign ld[i] = sel[i];
    end
    always_comb d = ld[i] ? wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RW_DEF[i];
      else        q <= d;
    end
    assign rw_q[i] = q;
  end

  always_comb begin
    nsup_d = sel[SL_VID] && over_ceiling;
    err_d  = wr_en && !(|sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsup_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      nsup_q <= nsup_d;
      err_q  <= err_d;
    end
  end

  // R3
  vid_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[SL_VID] && over_ceiling) |=> (nsup_q && rw_q[SL_VID] == $past(rw_q[SL_VID])));
  // R3
  vid_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld[SL_VID] |=> (rw_q[SL_VID] <= $past(rw_q[SL_VMAX]) && !nsup_q));
  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(|sel)) |=> (err_q && $stable(rw_q)));
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_q && nsup_q));
endmodule

// File: rtl/svid_telem.sv
`timescale 1ns/1ps
module svid_telem
  import svid_regbank_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  idx,
  input  logic           rd_en,
  input  logic [DW-1:0]  stat2_in,
  input  logic [DW-1:0]  iout_amps,
  input  logic [DW-1:0]  icc_meas,
  input  logic           icc_capture,
  output logic [DW-1:0]  icc_q,
  output logic [DW-1:0]  iout_code,
  output logic [DW-1:0]  shadow_q
);
  localparam logic [2*DW-1:0] FULL = (2*DW)'({DW{1'b1}});

  logic          cap_done_q, cap_done_d;
  logic [DW-1:0] icc_d, shadow_d;
  logic          cap_fire, shadow_fire;
  logic [2*DW-1:0] prod;

  always_comb begin
    cap_fire    = icc_capture && !cap_done_q;
    shadow_fire = rd_en && (idx == AW'(IX_STAT2));
    cap_done_d  = cap_done_q | cap_fire;
    icc_d       = cap_fire ? icc_meas : icc_q;
    shadow_d    = shadow_fire ? stat2_in : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_done_q <= 1'b0;
      icc_q      <= '0;
      shadow_q   <= '0;
    end else begin
      cap_done_q <= cap_done_d;
      icc_q      <= icc_d;
      shadow_q   <= shadow_d;
    end
  end

  // scaled current: full scale at the captured maximum
  always_comb begin
    prod = (2*DW)'(iout_amps) * FULL;
    if (icc_q == '0 || iout_amps >= icc_q) iout_code = {DW{1'b1}};
    else                                   iout_code = DW'(prod / (2*DW)'(icc_q));
  end

  // R5
  icc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done_q |=> $stable(icc_q));
  // R4
  shadow_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_fire |=> shadow_q == $past(stat2_in));
  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_fire |=> $stable(shadow_q));
endmodule

// File: rtl/svid_regbank.sv
`timescale 1ns/1ps
module svid_regbank
  import svid_regbank_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_idx,
  input  logic [7:0]    wr_data,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    stat1_in,
  input  logic [7:0]    stat2_in,
  input  logic [7:0]    iout_amps,
  input  logic [7:0]    vout_in,
  input  logic [7:0]    temp_in,
  input  logic [7:0]    icc_meas,
  input  logic          icc_capture,
  output logic [7:0]    rd_data,
  output logic          nsup_ack,
  output logic          err_ack,
  output logic [7:0]    vid_out,
  output logic [7:0]    pstate_out,
  output logic [7:0]    offset_out
);
  logic                    rst_n_s;
  logic [RW_N-1:0][DW-1:0] rw_q;
  logic [DW-1:0]           icc_q, iout_code, shadow_q;
  logic [DW-1:0]           rd_mux, rd_d;
  const_hit_t              cst;

  svid_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  svid_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .idx(reg_idx), .wdata(wr_data), .wr_en(wr_en),
    .rw_q(rw_q), .nsup_q(nsup_ack), .err_q(err_ack)
  );

  svid_telem #(.AW(AW)) u_tel (
    .clk(clk), .rst_n(rst_n_s), .idx(reg_idx), .rd_en(rd_en), .stat2_in(stat2_in),
    .iout_amps(iout_amps), .icc_meas(icc_meas), .icc_capture(icc_capture),
    .icc_q(icc_q), .iout_code(iout_code), .shadow_q(shadow_q)
  );

  always_comb begin
    cst    = const_lookup(DW'(reg_idx));
    rd_mux = '0;
    if (cst.hit) rd_mux = cst.val;
    for (int k = 0; k < RW_N; k++)
      if (reg_idx == AW'(RW_IDX[k])) rd_mux = rw_q[k];
    if (reg_idx == AW'(IX_STAT1))  rd_mux = stat1_in;
    if (reg_idx == AW'(IX_STAT2))  rd_mux = stat2_in;
    if (reg_idx == AW'(IX_IOUT))   rd_mux = iout_code;
    if (reg_idx == AW'(IX_VOUT))   rd_mux = vout_in;
    if (reg_idx == AW'(IX_TEMP))   rd_mux = temp_in;
    if (reg_idx == AW'(IX_SHADOW)) rd_mux = shadow_q;
    if (reg_idx == AW'(IX_ICCMAX)) rd_mux = icc_q;
    rd_d = rd_en ? rd_mux : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rd_data <= '0;
    else          rd_data <= rd_d;
  end

  assign vid_out    = rw_q[SL_VID];
  assign pstate_out = rw_q[SL_PST];
  assign offset_out = rw_q[SL_OFS];

  // R8
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && reg_idx == AW'(8'h12)) |=> rd_data == '0);
  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |=> $stable(rd_data));
  // R1
  vendor_id_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && reg_idx == AW'(8'h00)) |=> rd_data == 8'h1A);
endmodule

// File: tb/svid_regbank_test.sv
`timescale 1ns/1ps
module svid_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_idx = '0, wr_data = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] stat1_in = '0, stat2_in = '0, iout_amps = '0, vout_in = '0, temp_in = '0;
  logic [7:0] icc_meas = '0;
  logic       icc_capture = 1'b0;
  logic [7:0] rd_data, vid_out, pstate_out, offset_out;
  logic       nsup_ack, err_ack;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  svid_regbank uut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .stat1_in(stat1_in), .stat2_in(stat2_in), .iout_amps(iout_amps),
    .vout_in(vout_in), .temp_in(temp_in), .icc_meas(icc_meas), .icc_capture(icc_capture),
    .rd_data(rd_data), .nsup_ack(nsup_ack), .err_ack(err_ack), .vid_out(vid_out),
    .pstate_out(pstate_out), .offset_out(offset_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_tmax, m_vmax, m_vid, m_pst, m_ofs, m_sh, m_icc, m_rd;
  bit         m_cap, m_ns, m_er;
  int         m_rel;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return 8'h1A;  8'h01: return 8'h13;  8'h02: return 8'h01;
      8'h05: return 8'h02;  8'h06: return 8'hC7;  8'h24: return 8'h0A;
      8'h25: return 8'h02;
      8'h22: return m_tmax; 8'h30: return m_vmax; 8'h31: return m_vid;
      8'h32: return m_pst;  8'h33: return m_ofs;
      8'h10: return stat1_in; 8'h11: return stat2_in;
      8'h16: return vout_in;  8'h17: return temp_in;
      8'h1C: return m_sh;     8'h21: return m_icc;
      8'h15: begin
        if (m_icc == 0 || iout_amps >= m_icc) return 8'hFF;
        return 8'((int'(iout_amps) * 255) / int'(m_icc));
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_defaults();
    m_tmax = 8'h64; m_vmax = 8'hB5; m_vid = 0; m_pst = 0; m_ofs = 0;
    m_sh = 0; m_icc = 0; m_rd = 0; m_cap = 0; m_ns = 0; m_er = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_defaults();
    end else if (m_rel < 2) begin
      m_rel++; m_defaults();
    end else begin
      logic [7:0] rv;
      bit writable;
      rv = m_read(reg_idx);
      m_ns = 0; m_er = 0;
      if (rd_en) m_rd = rv;
      if (rd_en && reg_idx == 8'h11) m_sh = stat2_in;
      if (icc_capture && !m_cap) begin m_icc = icc_meas; m_cap = 1; end
      if (wr_en) begin
        writable = (reg_idx inside {8'h22, 8'h30, 8'h31, 8'h32, 8'h33});
        if (!writable) m_er = 1;
        else if (reg_idx == 8'h31) begin
          if (wr_data > m_vmax) m_ns = 1; else m_vid = wr_data;
        end
        else if (reg_idx == 8'h22) m_tmax = wr_data;
        else if (reg_idx == 8'h30) m_vmax = wr_data;
        else if (reg_idx == 8'h32) m_pst = wr_data;
        else m_ofs = wr_data;
      end
    end
  end

  task automatic cmp(input string name, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: %s got %02h exp %02h", cur_req, name, got, exp);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("rd_data", rd_data, m_rd);
      cmp("nsup_ack", {7'd0, nsup_ack}, {7'd0, m_ns});
      cmp("err_ack", {7'd0, err_ack}, {7'd0, m_er});
      cmp("vid_out", vid_out, m_vid);
      cmp("pstate_out", pstate_out, m_pst);
      cmp("offset_out", offset_out, m_ofs);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_rd(input logic [7:0] a);
    @(negedge clk); reg_idx = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_idx = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    cur_req = req;
    do_rd(a);
    cmp($sformatf("read %02h", a), rd_data, exp);
  endtask

  task automatic capture(input logic [7:0] v);
    @(negedge clk); icc_meas = v; icc_capture = 1'b1;
    @(negedge clk); icc_capture = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- directed and random sequences ----------------
  initial begin
    logic [7:0] list [16];
    list = '{8'h00, 8'h06, 8'h10, 8'h11, 8'h12, 8'h15, 8'h16, 8'h17,
             8'h1C, 8'h21, 8'h22, 8'h30, 8'h31, 8'h32, 8'h33, 8'h25};

    // R10: reset state and masked first edges
    repeat (3) @(negedge clk);
    cmp("reset rd_data", rd_data, 8'h00);
    cmp("reset vid_out", vid_out, 8'h00);
    rst_n = 1'b1;
    reg_idx = 8'h22; wr_data = 8'h11; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    expect_rd("R10", 8'h22, 8'h64);

    // R2 defaults
    expect_rd("R2", 8'h30, 8'hB5);
    expect_rd("R2", 8'h31, 8'h00);
    expect_rd("R2", 8'h33, 8'h00);

    // R1 identity bytes
    expect_rd("R1", 8'h00, 8'h1A);
    expect_rd("R1", 8'h01, 8'h13);
    expect_rd("R1", 8'h02, 8'h01);
    expect_rd("R1", 8'h05, 8'h02);
    expect_rd("R1", 8'h06, 8'hC7);
    expect_rd("R1", 8'h24, 8'h0A);
    expect_rd("R1", 8'h25, 8'h02);
    repeat (3) @(negedge clk);
    cur_req = "R1"; cmp("rd hold", rd_data, 8'h02);

    // R2 write/readback, R7 outputs
    cur_req = "R2"; do_wr(8'h22, 8'h5A);
    expect_rd("R2", 8'h22, 8'h5A);
    cur_req = "R7"; do_wr(8'h33, 8'hFF);
    cmp("offset_out -1", offset_out, 8'hFF);
    do_wr(8'h33, 8'h01);
    cmp("offset_out +1", offset_out, 8'h01);
    do_wr(8'h32, 8'h03);
    cmp("pstate_out", pstate_out, 8'h03);

    // R3 VID ceiling
    cur_req = "R3"; do_wr(8'h31, 8'hB6);
    cmp("nsup pulse", {7'd0, nsup_ack}, 8'h01);
    @(negedge clk);
    cmp("nsup one cycle", {7'd0, nsup_ack}, 8'h00);
    cmp("vid kept", vid_out, 8'h00);
    do_wr(8'h31, 8'hB5);
    cmp("vid at ceiling", vid_out, 8'hB5);
    cmp("no nsup", {7'd0, nsup_ack}, 8'h00);
    do_wr(8'h30, 8'h40);
    do_wr(8'h31, 8'h41);
    cmp("nsup lowered", {7'd0, nsup_ack}, 8'h01);
    expect_rd("R3", 8'h31, 8'hB5);
    cur_req = "R3"; do_wr(8'h31, 8'h40);
    cmp("vid accepted", vid_out, 8'h40);

    // R9 writes to non-writable indices
    cur_req = "R9"; do_wr(8'h00, 8'h55);
    cmp("err pulse", {7'd0, err_ack}, 8'h01);
    @(negedge clk);
    cmp("err one cycle", {7'd0, err_ack}, 8'h00);
    expect_rd("R9", 8'h00, 8'h1A);
    cur_req = "R9"; do_wr(8'h1C, 8'h77);
    expect_rd("R9", 8'h1C, 8'h00);

    // R5 capture, R6 scaling
    expect_rd("R5", 8'h21, 8'h00);
    iout_amps = 8'd10;
    expect_rd("R6", 8'h15, 8'hFF);
    capture(8'd50);
    expect_rd("R5", 8'h21, 8'd50);
    capture(8'd99);
    expect_rd("R5", 8'h21, 8'd50);
    iout_amps = 8'd25; expect_rd("R6", 8'h15, 8'h7F);
    iout_amps = 8'd49; expect_rd("R6", 8'h15, 8'hF9);
    iout_amps = 8'd50; expect_rd("R6", 8'h15, 8'hFF);
    iout_amps = 8'd60; expect_rd("R6", 8'h15, 8'hFF);
    iout_amps = 8'd0;  expect_rd("R6", 8'h15, 8'h00);

    // R4 shadow
    stat2_in = 8'hA5;
    expect_rd("R4", 8'h11, 8'hA5);
    expect_rd("R4", 8'h1C, 8'hA5);
    stat2_in = 8'h3C;
    expect_rd("R4", 8'h1C, 8'hA5);
    expect_rd("R4", 8'h11, 8'h3C);
    expect_rd("R4", 8'h1C, 8'h3C);

    // R11 live telemetry
    stat1_in = 8'h77; vout_in = 8'h9B; temp_in = 8'h2D;
    expect_rd("R11", 8'h10, 8'h77);
    expect_rd("R11", 8'h16, 8'h9B);
    expect_rd("R11", 8'h17, 8'h2D);

    // R8 holes
    expect_rd("R8", 8'h03, 8'h00);
    expect_rd("R8", 8'h12, 8'h00);
    expect_rd("R8", 8'hFF, 8'h00);

    // mixed pseudo-random run, checked by the model every clock (R2 R3 R4 R9)
    cur_req = "R3";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      reg_idx     = list[$urandom_range(0, 15)];
      wr_data     = 8'($urandom_range(0, 255));
      wr_en       = ($urandom_range(0, 2) == 0);
      rd_en       = ($urandom_range(0, 1) == 0);
      stat2_in    = 8'($urandom_range(0, 255));
      iout_amps   = 8'($urandom_range(0, 80));
      icc_capture = ($urandom_range(0, 7) == 0);
      icc_meas    = 8'($urandom_range(0, 255));
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; icc_capture = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule